// File: doc/BRIEF.md
# Pulse-Train LMS Weight Update Sequencer

This block runs one least-mean-square adaptation pass over a bank of analog weights. Each weight can only be moved in unit steps, and a unit step is one programming pulse on either a positive-branch or a negative-branch switch. A host sets the desired output value, one signed input sample per weight, a learning-rate shift and a pulse ceiling. It then raises `start`. The sequencer averages a block of ADC output codes into a measured value. For each weight it forms an integer step from the error and that weight's input, picks the switch branch from the step's sign, and emits one fixed-width pulse per unit of step magnitude.

Weights are visited one at a time, from the highest index down to index 0. Index i belongs to channel i / NUM_TAP and tap i % NUM_TAP. A guard interval separates every switch change from pulse activity. At the end of the pass a one-cycle `done` strobe is raised, and the number of pulses issued in the pass is held on an output.

Top module: `lms_pulse_seq`

## Requirements
- R1: A pass starts when `start` is high while `busy` is low. The sequencer then takes exactly N_SAMP codes from `smp_data` on cycles with `smp_valid` high. The measured value M is their sum shifted right by log2(N_SAMP). Codes offered while idle, on cycles with `smp_valid` low, or after the N_SAMP-th code do not affect M.
- R2: The step for weight i is S = floor(2 × (D − M) × X[i] / 2^mu), computed as an arithmetic right shift. D is the unsigned desired code, X[i] is the signed DW-bit field at bits [i×DW +: DW] of `x_vec`, and mu is the value on `mu_shift`. So a step of −1/16 rounds to −1.
- R3: If S < 0, `sel_neg` is raised; otherwise `sel_pos` is raised. The two selects are never high together, and `pulse` is only ever high while exactly one select is high.
- R4: The number of pulses issued for a weight is min(|S|, max_pulses), where max_pulses is the value on `max_pulses`.
- R5: Every pulse is high for exactly PULSE_CYC consecutive cycles.
- R6: After a select rises, `pulse` stays low for exactly GUARD_CYC cycles before the first pulse. Consecutive pulses are separated by exactly GUARD_CYC low cycles. The selects are held constant while `pulse` is high, and they never change in a cycle next to a pulse-high cycle.
- R7: Weights with a nonzero pulse count are served in descending index order, from NUM_CH×NUM_TAP−1 down to 0. `weight_idx` shows the weight being served and holds steady while a select is high.
- R8: A weight whose pulse count is zero produces no select activity and no pulse.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle after the last weight, with `busy` still high, and `busy` is low in the following cycle.
- R10: A `start` received while `busy` is high is ignored. D, X, mu and max_pulses are captured when a pass starts, so later changes on those ports have no effect on the running pass.
- R11: `pulse_total` is cleared when a pass starts and rises by one at each pulse rising edge. During `done` it holds the pass total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pass request |
| smp_valid | input | 1 | ADC code strobe |
| smp_data | input | DW | ADC output code, unsigned |
| desired | input | DW | Desired output code, unsigned |
| x_vec | input | NUM_CH×NUM_TAP×DW | Signed input sample per weight |
| mu_shift | input | SW | Learning-rate right shift |
| max_pulses | input | CW | Ceiling on pulses per weight |
| sel_pos | output | 1 | Positive-branch switch select |
| sel_neg | output | 1 | Negative-branch switch select |
| pulse | output | 1 | Programming pulse |
| weight_idx | output | $clog2(NUM_CH×NUM_TAP) | Weight being served |
| busy | output | 1 | Pass in progress |
| done | output | 1 | End-of-pass strobe |
| pulse_total | output | CW+$clog2(NUM_CH×NUM_TAP+1) | Pulses issued in the pass |

## Verification
`busy` is due one cycle after the edge that samples `start`. The first select rises two cycles after the N_SAMP-th code is taken. Pulse edges then follow a fixed rhythm: GUARD_CYC low cycles, PULSE_CYC high cycles, and so on. `done` appears in the same cycle that the last select falls. When no weight is served, `done` appears right after the per-weight visits. The bench samples every output on the falling clock edge. It measures the guard and pulse-high run lengths cycle by cycle against those exact counts. When each select falls, it compares the served weight, branch and pulse count with the next item its driver queued. This tolerates the variable number of cycles a pass takes without giving up the exact per-pulse timing.

// File: rtl/lms_seq_pkg.sv
// Package: shared state encoding for the pulse-train LMS sequencer.
// Assumes nothing beyond a single clock domain.
package lms_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT,
        ST_WGT,
        ST_GUARD,
        ST_HIGH,
        ST_GAP,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/lms_seq_capture.sv
// Sample capture: accumulates N_SAMP ADC codes after a clear and presents
// their mean. Assumes N_SAMP is a power of two so the mean is a shift.
module lms_seq_capture #(
    parameter int DW     = 12,
    parameter int N_SAMP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic [DW-1:0] data,
    output logic          filled,
    output logic [DW-1:0] mean
);
    localparam int LOG2N = $clog2(N_SAMP);
    localparam int AW    = DW + LOG2N;
    localparam int NCW   = $clog2(N_SAMP + 1);

    logic [AW-1:0]  acc;
    logic [NCW-1:0] left;

    // Down-count the remaining samples and accumulate each accepted code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            left <= '0;
        end else if (clear) begin
            acc  <= '0;
            left <= NCW'(N_SAMP);
        end else if (take && left != '0) begin
            acc  <= acc + AW'(data);
            left <= left - 1'b1;
        end
    end

    assign filled = (left == '0);
    assign mean   = acc[AW-1:LOG2N];
endmodule

// File: rtl/lms_seq_step.sv
// Step calculator: forms floor(2*(desired-mean)*x / 2^mu), returns its sign
// and its magnitude clipped to the pulse ceiling. Purely combinational.
module lms_seq_step #(
    parameter int DW = 12,
    parameter int CW = 8,
    parameter int SW = 4
) (
    input  logic          [DW-1:0] mean,
    input  logic          [DW-1:0] desired,
    input  logic signed   [DW-1:0] x_in,
    input  logic          [SW-1:0] mu,
    input  logic          [CW-1:0] max_p,
    output logic                   neg,
    output logic          [CW-1:0] mag
);
    localparam int PW = 2 * DW + 2;

    logic signed [DW:0]   diff;
    logic signed [PW-1:0] diff_e;
    logic signed [PW-1:0] x_e;
    logic signed [PW-1:0] prod2;
    logic signed [PW-1:0] scaled;
    logic        [PW-1:0] mag_full;

    // Signed error, doubled product and learning-rate shift.
    always_comb begin
        diff     = $signed({1'b0, desired}) - $signed({1'b0, mean});
        diff_e   = PW'(diff);
        x_e      = PW'(x_in);
        prod2    = (diff_e * x_e) <<< 1;
        scaled   = prod2 >>> mu;
        neg      = scaled[PW-1];
        mag_full = neg ? PW'(-scaled) : PW'(scaled);
    end

    // Clip the magnitude to the programmed ceiling.
    always_comb begin
        if (mag_full > PW'(max_p)) mag = max_p;
        else                       mag = mag_full[CW-1:0];
    end
endmodule

// File: rtl/lms_seq_timer.sv
// Interval timer: loads a count and counts down to zero. Loading N-1 marks
// an interval of N cycles. Assumes load values fit in TMW bits.
module lms_seq_timer #(
    parameter int TMW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [TMW-1:0] load_val,
    output logic           expired
);
    logic [TMW-1:0] cnt;

    // Reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lms_pulse_seq.sv
// Pulse-train LMS weight update sequencer (top).
// Runs one adaptation pass: capture N_SAMP codes, then for each weight from
// the highest index down, select a branch switch by step sign and issue
// min(|step|, max_pulses) pulses of PULSE_CYC cycles, with GUARD_CYC low
// cycles around every pulse. Assumes N_SAMP a power of two, GUARD_CYC >= 1,
// PULSE_CYC >= 1, NUM_CH*NUM_TAP >= 2.
module lms_pulse_seq #(
    parameter int NUM_CH    = 4,
    parameter int NUM_TAP   = 3,
    parameter int N_SAMP    = 8,
    parameter int DW        = 12,
    parameter int CW        = 8,
    parameter int SW        = 4,
    parameter int PULSE_CYC = 125,
    parameter int GUARD_CYC = 2,
    localparam int NW       = NUM_CH * NUM_TAP,
    localparam int IW       = $clog2(NW),
    localparam int KW       = $clog2(NW + 1),
    localparam int TW       = CW + KW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    input  logic [DW-1:0]    desired,
    input  logic [NW*DW-1:0] x_vec,
    input  logic [SW-1:0]    mu_shift,
    input  logic [CW-1:0]    max_pulses,
    output logic             sel_pos,
    output logic             sel_neg,
    output logic             pulse,
    output logic [IW-1:0]    weight_idx,
    output logic             busy,
    output logic             done,
    output logic [TW-1:0]    pulse_total
);
    import lms_seq_pkg::*;

    localparam int TMAX = (PULSE_CYC > GUARD_CYC) ? PULSE_CYC : GUARD_CYC;
    localparam int TMW  = $clog2(TMAX + 1);
    localparam logic [TMW-1:0] PULSE_LD = TMW'(PULSE_CYC - 1);
    localparam logic [TMW-1:0] GUARD_LD = TMW'(GUARD_CYC - 1);

    seq_state_t          state;
    logic [DW-1:0]       des_q;
    logic [NW*DW-1:0]    x_q;
    logic [SW-1:0]       mu_q;
    logic [CW-1:0]       maxp_q;
    logic [KW-1:0]       wcnt;
    logic [CW-1:0]       rem;
    logic [DW-1:0]       mean;
    logic                filled;
    logic                cap_clear;
    logic                cap_take;
    logic                step_neg;
    logic [CW-1:0]       step_mag;
    logic signed [DW-1:0] x_cur;
    logic                tmr_load;
    logic [TMW-1:0]      tmr_val;
    logic                tmr_exp;
    logic                accept;

    assign accept     = (state == ST_IDLE) && start;
    assign cap_clear  = accept;
    assign cap_take   = (state == ST_CAPT) && smp_valid;
    assign weight_idx = IW'(wcnt - 1'b1);
    assign x_cur      = x_q[int'(weight_idx) * DW +: DW];
    assign pulse      = (state == ST_HIGH);
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);

    lms_seq_capture #(.DW(DW), .N_SAMP(N_SAMP)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cap_clear),
        .take   (cap_take),
        .data   (smp_data),
        .filled (filled),
        .mean   (mean)
    );

    lms_seq_step #(.DW(DW), .CW(CW), .SW(SW)) u_step (
        .mean    (mean),
        .desired (des_q),
        .x_in    (x_cur),
        .mu      (mu_q),
        .max_p   (maxp_q),
        .neg     (step_neg),
        .mag     (step_mag)
    );

    lms_seq_timer #(.TMW(TMW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Choose when the interval timer restarts and for how long.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_WGT:   if (step_mag != '0) begin tmr_load = 1'b1; tmr_val = GUARD_LD; end
            ST_GUARD: if (tmr_exp)        begin tmr_load = 1'b1; tmr_val = PULSE_LD; end
            ST_HIGH:  if (tmr_exp)        begin tmr_load = 1'b1; tmr_val = GUARD_LD; end
            ST_GAP:   if (tmr_exp && rem != '0) begin tmr_load = 1'b1; tmr_val = PULSE_LD; end
            default:  ;
        endcase
    end

    // Pass sequencing: capture, per-weight select/pulse train, end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            des_q       <= '0;
            x_q         <= '0;
            mu_q        <= '0;
            maxp_q      <= '0;
            wcnt        <= '0;
            rem         <= '0;
            sel_pos     <= 1'b0;
            sel_neg     <= 1'b0;
            pulse_total <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    des_q       <= desired;
                    x_q         <= x_vec;
                    mu_q        <= mu_shift;
                    maxp_q      <= max_pulses;
                    pulse_total <= '0;
                    state       <= ST_CAPT;
                end
                ST_CAPT: if (filled) begin
                    wcnt  <= KW'(NW);
                    state <= ST_WGT;
                end
                ST_WGT: begin
                    if (step_mag == '0) begin
                        wcnt  <= wcnt - 1'b1;
                        state <= (wcnt == KW'(1)) ? ST_DONE : ST_WGT;
                    end else begin
                        sel_pos <= !step_neg;
                        sel_neg <= step_neg;
                        rem     <= step_mag;
                        state   <= ST_GUARD;
                    end
                end
                ST_GUARD: if (tmr_exp) begin
                    pulse_total <= pulse_total + 1'b1;
                    state       <= ST_HIGH;
                end
                ST_HIGH: if (tmr_exp) begin
                    rem   <= rem - 1'b1;
                    state <= ST_GAP;
                end
                ST_GAP: if (tmr_exp) begin
                    if (rem != '0) begin
                        pulse_total <= pulse_total + 1'b1;
                        state       <= ST_HIGH;
                    end else begin
                        sel_pos <= 1'b0;
                        sel_neg <= 1'b0;
                        wcnt    <= wcnt - 1'b1;
                        state   <= (wcnt == KW'(1)) ? ST_DONE : ST_WGT;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lms_pulse_seq_chk.sv
// Checker: temporal properties of the sequencer's ports, bound to the top.
// Assumes synchronous active-low reset on the same clock.
module lms_pulse_seq_chk #(
    parameter int IW = 4,
    parameter int TW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          pulse,
    input logic          sel_pos,
    input logic          sel_neg,
    input logic [IW-1:0] weight_idx,
    input logic [TW-1:0] pulse_total
);
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({sel_pos, sel_neg})); // R3
    AST_PULSE_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> (sel_pos || sel_neg)); // R3
    AST_SEL_HELD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> $stable({sel_pos, sel_neg})); // R6
    AST_SEL_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$stable({sel_pos, sel_neg}) |-> (!pulse && !$past(pulse))); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((sel_pos || sel_neg) && $past(sel_pos || sel_neg)) |-> $stable(weight_idx)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R9
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R9
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R9
    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse) |-> (pulse_total == $past(pulse_total) + 1'b1)); // R11
endmodule

bind lms_pulse_seq lms_pulse_seq_chk #(.IW(IW), .TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .pulse       (pulse),
    .sel_pos     (sel_pos),
    .sel_neg     (sel_neg),
    .weight_idx  (weight_idx),
    .pulse_total (pulse_total)
);

// File: tb/lms_pulse_seq_test.sv
// Scoreboard bench: the driver queues expected (index, branch, count) items,
// the monitor checks pulse timing and pops items as each select falls.
module lms_pulse_seq_test;
    localparam int NUM_CH = 4;
    localparam int NUM_TAP = 3;
    localparam int NW = NUM_CH * NUM_TAP;
    localparam int NS = 8;
    localparam int LOG2N = 3;
    localparam int DW = 12;
    localparam int CW = 8;
    localparam int SW = 4;
    localparam int PULSE = 6;
    localparam int GUARD = 2;
    localparam int IW = $clog2(NW);
    localparam int TW = CW + $clog2(NW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [DW-1:0] desired = '0;
    logic [NW*DW-1:0] x_vec = '0;
    logic [SW-1:0] mu_shift = '0;
    logic [CW-1:0] max_pulses = '0;
    logic sel_pos, sel_neg, pulse, busy, done;
    logic [IW-1:0] weight_idx;
    logic [TW-1:0] pulse_total;

    always #4 clk = ~clk;

    lms_pulse_seq #(.NUM_CH(NUM_CH), .NUM_TAP(NUM_TAP), .N_SAMP(NS), .DW(DW), .CW(CW),
                    .SW(SW), .PULSE_CYC(PULSE), .GUARD_CYC(GUARD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp_data(smp_data),
        .desired(desired), .x_vec(x_vec), .mu_shift(mu_shift), .max_pulses(max_pulses),
        .sel_pos(sel_pos), .sel_neg(sel_neg), .pulse(pulse), .weight_idx(weight_idx),
        .busy(busy), .done(done), .pulse_total(pulse_total));

    int n_run = 0;
    int n_fail = 0;
    int exp_q[$];
    int exp_total = 0;
    int done_seen = 0;
    int xs[NW];
    int samp[NS];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: computes expected items from R1/R2/R4, queues them, runs a pass.
    task automatic run_pass(input int d, input int mu, input int maxp, input bit inject);
        int sum = 0;
        int mean;
        int prev_done;
        longint st, mag;
        for (int j = 0; j < NS; j++) sum += samp[j];
        mean = sum >> LOG2N;
        exp_total = 0;
        for (int i = NW - 1; i >= 0; i--) begin
            st = (2 * longint'(d - mean) * longint'(xs[i])) >>> mu;
            mag = (st < 0) ? -st : st;
            if (mag > maxp) mag = maxp;
            if (mag != 0) exp_q.push_back((i << 16) | ((st < 0) ? 32'h8000 : 0) | int'(mag));
            exp_total += int'(mag);
        end
        prev_done = done_seen;
        @(negedge clk);
        desired = DW'(d);
        for (int i = 0; i < NW; i++) x_vec[i*DW +: DW] = DW'(xs[i]);
        mu_shift = SW'(mu);
        max_pulses = CW'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        for (int j = 0; j < NS; j++) begin
            if (j % 3 == 1) begin
                smp_valid = 1'b0; smp_data = '1;
                @(negedge clk);
            end
            smp_valid = 1'b1; smp_data = DW'(samp[j]);
            @(negedge clk);
        end
        smp_data = '1;
        @(negedge clk);
        smp_valid = 1'b0;
        if (inject) begin
            repeat (15) @(negedge clk);
            start = 1'b1; desired = '1; x_vec = '1; mu_shift = '0; max_pulses = '1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_seen == prev_done && !finished) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R10 no second pass after ignored start", busy, 0);
    endtask

    // Monitor: run lengths (R5 R6), branch/index/count (R3 R4 R7 R8), end (R9 R11).
    logic [1:0] prev_sel = 2'b00;
    logic prev_pulse = 1'b0, prev_done = 1'b0;
    int cur_idx = 0, cur_neg = 0, pcnt = 0, lowrun = 0, hirun = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] sel;
            sel = {sel_neg, sel_pos};
            if (sel != 2'b00 && prev_sel == 2'b00) begin
                cur_idx = int'(weight_idx); cur_neg = int'(sel_neg); pcnt = 0; lowrun = 0;
            end
            if (sel != 2'b00 && prev_sel != 2'b00 && sel != prev_sel)
                chk(1'b0, "R3 branch changed within weight", sel, prev_sel);
            if (sel != 2'b00) begin
                if (pulse && !prev_pulse) begin
                    chk(lowrun == GUARD, "R6 guard low cycles", lowrun, GUARD);
                    pcnt++; hirun = 1;
                end else if (pulse) hirun++;
                else if (prev_pulse) begin
                    chk(hirun == PULSE, "R5 pulse width", hirun, PULSE);
                    lowrun = 1;
                end else lowrun++;
            end else if (pulse) chk(1'b0, "R3 pulse without select", pulse, 0);
            if (sel == 2'b00 && prev_sel != 2'b00) begin
                if (exp_q.size() == 0) chk(1'b0, "R8 unexpected weight served", cur_idx, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cur_idx == (e >> 16), "R7 weight order", cur_idx, e >> 16);
                    chk(cur_neg == ((e >> 15) & 1), "R3 branch (R2 sign)", cur_neg, (e >> 15) & 1);
                    chk(pcnt == (e & 16'h7fff), "R4 pulse count (R1 R2 step)", pcnt, e & 16'h7fff);
                end
            end
            if (done) begin
                chk(exp_q.size() == 0, "R8 R9 all weights served at done", exp_q.size(), 0);
                chk(int'(pulse_total) == exp_total, "R11 pulse total", pulse_total, exp_total);
                if (prev_done) chk(1'b0, "R9 done longer than one cycle", 2, 1);
                done_seen++;
            end
            prev_sel = sel; prev_pulse = pulse; prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            chk(1'b0, "watchdog", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && pulse == 0, "R9 reset state idle", {busy, done, pulse}, 0);
        chk({sel_pos, sel_neg} == 2'b00 && pulse_total == '0, "R3 R11 reset outputs", {sel_pos, sel_neg}, 0);
        // Codes offered while idle must not count (R1).
        smp_valid = 1'b1; smp_data = '1;
        repeat (5) @(negedge clk);
        smp_valid = 1'b0;
        chk(busy == 1'b0, "R1 idle samples start nothing", busy, 0);
        // Pass A: positive error, mixed inputs, clipping, -1 rounding, zero skips.
        for (int j = 0; j < NS; j++) samp[j] = 1000 + j;
        xs = '{3, -5, 0, 100, -1, 1, -100, 2, 7, -3, 20, -20};
        run_pass(1010, 4, 5, 0);
        // Pass B: negative error, large shift.
        for (int j = 0; j < NS; j++) samp[j] = 600;
        xs = '{5, -5, 50, -80, 300, 0, -1, 12, -12, 51, -51, 1};
        run_pass(500, 10, 15, 0);
        // Pass C: zero ceiling, every weight skipped (R8).
        run_pass(500, 10, 0, 0);
        // Pass D: no shift, start and port changes during the pass (R10).
        for (int j = 0; j < NS; j++) samp[j] = 1;
        xs = '{1, -1, 0, 2, -2, 1, 0, 0, -1, 1, 0, 3};
        run_pass(2, 0, 3, 1);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule